// File: doc/BRIEF.md
# Parallel-Layer Cell Resequencer

This block serves one output of a switch built from several slower switching layers in parallel. Each of the `LANES` layer links delivers cells for this output at a fraction of the line rate. Because the layers queue independently, cells reach the block in an order that can differ from the order in which they entered the switch. Every cell carries a timestamp: the line slot in which it arrived at the switch input. The block accepts cells from all layers as soon as they appear. It holds them in a bounded buffer and puts them back on one line-rate output in timestamp order, each after a fixed delay.

Time is counted in line slots by a free-running counter (`slot_now`) that advances by one every clock. A stored cell becomes due once its age (`slot_now` minus its timestamp, modulo 2^`TS_W`) reaches `REL_OFS` = `PORTS`×`LANES` line slots. In each slot the oldest due cell is sent. The buffer holds `PORTS`×`LANES` cells. The block drops a cell and raises a one-cycle error flag when the cell arrives too late to be released on time, or when no buffer entry can take it.

Top module: `reseq_mux`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_vld`, `err_late` and `err_ovf` are 0 and `slot_now` is 0 until the first rising clock edge with `rst_n` high.
- R2: `slot_now` advances by exactly one on each clock edge after reset and wraps modulo 2^`TS_W`.
- R3: A lane cell counts as late when its age, (`slot_now` − `lane_ts[l]`) mod 2^`TS_W`, is `REL_OFS` or more. This includes timestamps ahead of `slot_now`. A late cell is dropped and never appears at the output, and `err_late` is 1 in the following cycle. An age of `REL_OFS`−1 is still accepted.
- R4: An accepted cell keeps its timestamp and data unchanged. When all timestamps are distinct, the cell appears with `out_vld`=1 in the cycle after the one in which its age equals `REL_OFS`, which is `REL_OFS`+1 slots after its timestamp.
- R5: Among stored cells whose age is at least `REL_OFS`, the one with the greatest age is sent. The sequence of `out_ts` values never steps backwards in modular time.
- R6: In a cycle with no due cell in the buffer, `out_vld` is 0 in the following cycle.
- R7: The buffer holds `PORTS`×`LANES` cells. An entry released in a cycle can take a new cell in that same cycle, so a full-rate stream of age-0 cells keeps the buffer full without loss.
- R8: When arriving cells outnumber the free entries, the cells on the higher-numbered lanes are dropped first, and `err_ovf` is 1 in the following cycle.
- R9: Cells that reach the block out of order across lanes (for example, newer timestamps on lower lanes, or mixed ages in one cycle) still leave in timestamp order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_vld | input | LANES | Per-layer cell present |
| lane_ts | input | LANES×TS_W | Per-layer cell timestamp (input arrival slot) |
| lane_data | input | LANES×DATA_W | Per-layer cell payload |
| out_vld | output | 1 | Output cell present |
| out_ts | output | TS_W | Timestamp of the output cell |
| out_data | output | DATA_W | Payload of the output cell |
| err_late | output | 1 | A cell arrived past its release slot in the previous cycle |
| err_ovf | output | 1 | A cell found no free buffer entry in the previous cycle |
| slot_now | output | TS_W | Current line-slot count |

## Verification
On every cycle, the assertions check the slot counter's step, that no cell leaves before its release offset, that output timestamps never go backwards, that the output is idle when no cell is due, and that each late or overflow event raises its flag and that no flag appears without a cause. Only the bench scenarios can show the exact slot in which each cell leaves and that its payload is intact. They also show which lane loses under overflow and that the buffer stays lossless at full rate with same-cycle entry reuse. They also confirm that ordered, reversed and widely scattered lane arrival patterns all come out in timestamp order.

// File: rtl/reseq_pkg.sv
package reseq_pkg;

  // Widest timestamp the helper functions handle.
  localparam int unsigned WIDE_W = 16;
  typedef logic [WIDE_W-1:0] wide_t;

  // Modular distance from a timestamp to the current slot, over a w-bit counter.
  function automatic wide_t slot_age(wide_t now_v, wide_t ts_v, int unsigned w);
    wide_t span_mask;
    span_mask = wide_t'((32'd1 << w) - 32'd1);
    return (now_v - ts_v) & span_mask;
  endfunction

  // A cell of this age has reached (or passed) its release slot.
  function automatic logic is_due(wide_t age, int unsigned ofs);
    return age >= wide_t'(ofs);
  endfunction

endpackage

// File: rtl/reseq_lane.sv
module reseq_lane
  import reseq_pkg::*;
#(
  parameter int TS_W    = 5,
  parameter int REL_OFS = 12
) (
  input  logic            cell_vld,
  input  logic [TS_W-1:0] cell_ts,
  input  logic [TS_W-1:0] now,
  output logic            keep,
  output logic            late
);

  wide_t age;

  always_comb begin
    age  = slot_age(wide_t'(now), wide_t'(cell_ts), TS_W);
    late = cell_vld && is_due(age, REL_OFS);
    keep = cell_vld && !late;
  end

endmodule

// File: rtl/reseq_alloc.sv
module reseq_alloc #(
  parameter int LANES = 3,
  parameter int DEPTH = 12,
  parameter int IDX_W = 4
) (
  input  logic [DEPTH-1:0]            free_mask,
  input  logic [LANES-1:0]            req,
  output logic [LANES-1:0]            grant,
  output logic [LANES-1:0][IDX_W-1:0] slot,
  output logic [LANES-1:0]            ovf
);

  logic [DEPTH-1:0] avail;
  logic             found;

  // Lower lanes claim the lowest free entries first.
  always_comb begin
    avail = free_mask;
    found = 1'b0;
    grant = '0;
    slot  = '0;
    ovf   = '0;
    for (int l = 0; l < LANES; l++) begin
      found = 1'b0;
      if (req[l]) begin
        for (int d = 0; d < DEPTH; d++) begin
          if (!found && avail[d]) begin
            found    = 1'b1;
            slot[l]  = IDX_W'(d);
            avail[d] = 1'b0;
          end
        end
        grant[l] = found;
        ovf[l]   = !found;
      end
    end
  end

endmodule

// File: rtl/reseq_store.sv
module reseq_store #(
  parameter int LANES  = 3,
  parameter int DEPTH  = 12,
  parameter int IDX_W  = 4,
  parameter int TS_W   = 5,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            wr_en,
  input  logic [LANES-1:0][IDX_W-1:0] wr_slot,
  input  logic [LANES-1:0][TS_W-1:0]  wr_ts,
  input  logic [LANES-1:0][DATA_W-1:0] wr_data,
  input  logic                        clr_en,
  input  logic [IDX_W-1:0]            clr_slot,
  output logic [DEPTH-1:0]            occ,
  output logic [DEPTH-1:0][TS_W-1:0]  ent_ts,
  output logic [DEPTH-1:0][DATA_W-1:0] ent_data
);

  // Occupancy: a write in the same cycle as a release of that entry wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      if (clr_en) occ[clr_slot] <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l]) occ[wr_slot[l]] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en[l]) begin
        ent_ts[wr_slot[l]]   <= wr_ts[l];
        ent_data[wr_slot[l]] <= wr_data[l];
      end
    end
  end

endmodule

// File: rtl/reseq_pick.sv
module reseq_pick
  import reseq_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int IDX_W   = 4,
  parameter int TS_W    = 5,
  parameter int REL_OFS = 12
) (
  input  logic [DEPTH-1:0]           occ,
  input  logic [DEPTH-1:0][TS_W-1:0] ent_ts,
  input  logic [TS_W-1:0]            now,
  output logic                       pick_vld,
  output logic [IDX_W-1:0]           pick_idx
);

  wide_t age;
  wide_t best_age;

  // Oldest due entry wins; equal ages go to the lowest index.
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    best_age = '0;
    age      = '0;
    for (int d = 0; d < DEPTH; d++) begin
      age = slot_age(wide_t'(now), wide_t'(ent_ts[d]), TS_W);
      if (occ[d] && is_due(age, REL_OFS) && (!pick_vld || age > best_age)) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(d);
        best_age = age;
      end
    end
  end

endmodule

// File: rtl/reseq_mux.sv
module reseq_mux #(
  parameter int LANES  = 3,
  parameter int PORTS  = 4,
  parameter int TS_W   = 5,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             lane_vld,
  input  logic [LANES-1:0][TS_W-1:0]   lane_ts,
  input  logic [LANES-1:0][DATA_W-1:0] lane_data,
  output logic                         out_vld,
  output logic [TS_W-1:0]              out_ts,
  output logic [DATA_W-1:0]            out_data,
  output logic                         err_late,
  output logic                         err_ovf,
  output logic [TS_W-1:0]              slot_now
);

  localparam int DEPTH   = PORTS * LANES;
  localparam int REL_OFS = PORTS * LANES;
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Named internal events, also visible to the checker.
  logic [LANES-1:0]             keep_vec;
  logic [LANES-1:0]             late_vec;
  logic [LANES-1:0]             grant_vec;
  logic [LANES-1:0]             ovf_vec;
  logic [LANES-1:0][IDX_W-1:0]  slot_vec;
  logic [DEPTH-1:0]             occ;
  logic [DEPTH-1:0][TS_W-1:0]   ent_ts;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0]             clr_hot;
  logic [DEPTH-1:0]             free_mask;
  logic                         pick_vld;
  logic [IDX_W-1:0]             pick_idx;
  logic [TS_W-1:0]              slot_q;

  assign slot_now = slot_q;

  // Per-lane capture and lateness test.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    reseq_lane #(
      .TS_W    (TS_W),
      .REL_OFS (REL_OFS)
    ) u_lane (
      .cell_vld (lane_vld[l]),
      .cell_ts  (lane_ts[l]),
      .now      (slot_q),
      .keep     (keep_vec[l]),
      .late     (late_vec[l])
    );
  end

  // The entry released this cycle is reusable at once.
  assign clr_hot   = pick_vld ? (DEPTH'(1) << pick_idx) : '0;
  assign free_mask = ~occ | clr_hot;

  reseq_alloc #(
    .LANES (LANES),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_alloc (
    .free_mask (free_mask),
    .req       (keep_vec),
    .grant     (grant_vec),
    .slot      (slot_vec),
    .ovf       (ovf_vec)
  );

  reseq_store #(
    .LANES  (LANES),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .TS_W   (TS_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (grant_vec),
    .wr_slot  (slot_vec),
    .wr_ts    (lane_ts),
    .wr_data  (lane_data),
    .clr_en   (pick_vld),
    .clr_slot (pick_idx),
    .occ      (occ),
    .ent_ts   (ent_ts),
    .ent_data (ent_data)
  );

  reseq_pick #(
    .DEPTH   (DEPTH),
    .IDX_W   (IDX_W),
    .TS_W    (TS_W),
    .REL_OFS (REL_OFS)
  ) u_pick (
    .occ      (occ),
    .ent_ts   (ent_ts),
    .now      (slot_q),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  // Slot counter, output stage and error pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      out_vld  <= 1'b0;
      out_ts   <= '0;
      out_data <= '0;
      err_late <= 1'b0;
      err_ovf  <= 1'b0;
    end else begin
      slot_q   <= slot_q + 1'b1;
      out_vld  <= pick_vld;
      if (pick_vld) begin
        out_ts   <= ent_ts[pick_idx];
        out_data <= ent_data[pick_idx];
      end
      err_late <= |late_vec;
      err_ovf  <= |ovf_vec;
    end
  end

endmodule

// File: rtl/reseq_mux_chk.sv
module reseq_mux_chk
  import reseq_pkg::*;
#(
  parameter int LANES   = 3,
  parameter int TS_W    = 5,
  parameter int DEPTH   = 12,
  parameter int REL_OFS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TS_W-1:0]  slot_now,
  input logic             out_vld,
  input logic [TS_W-1:0]  out_ts,
  input logic             err_late,
  input logic             err_ovf,
  input logic [LANES-1:0] late_vec,
  input logic [LANES-1:0] keep_vec,
  input logic [LANES-1:0] ovf_vec,
  input logic [DEPTH-1:0] free_mask,
  input logic [DEPTH-1:0] occ,
  input logic             pick_vld
);

  logic            have_last;
  logic [TS_W-1:0] last_ts;

  // Last released timestamp; forgotten once the buffer drains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_ts   <= '0;
    end else if (out_vld) begin
      have_last <= 1'b1;
      last_ts   <= out_ts;
    end else if (occ == '0) begin
      have_last <= 1'b0;
    end
  end

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot_now == $past(slot_now) + 1'b1);

  // R4
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> slot_age(wide_t'(slot_now), wide_t'(out_ts), TS_W) > wide_t'(REL_OFS));

  // R5
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && have_last) |->
      slot_age(wide_t'(out_ts), wide_t'(last_ts), TS_W) < wide_t'(32'd1 << (TS_W - 1)));

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_vld |=> !out_vld);

  // R3
  late_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|late_vec) |=> err_late);

  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_vec) |=> err_ovf);

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> $past($countones(keep_vec) > $countones(free_mask)));

endmodule

bind reseq_mux reseq_mux_chk #(
  .LANES   (LANES),
  .TS_W    (TS_W),
  .DEPTH   (DEPTH),
  .REL_OFS (REL_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_now  (slot_now),
  .out_vld   (out_vld),
  .out_ts    (out_ts),
  .err_late  (err_late),
  .err_ovf   (err_ovf),
  .late_vec  (late_vec),
  .keep_vec  (keep_vec),
  .ovf_vec   (ovf_vec),
  .free_mask (free_mask),
  .occ       (occ),
  .pick_vld  (pick_vld)
);

// File: tb/reseq_mux_test.sv
module reseq_mux_test;

  localparam int LANES  = 3;
  localparam int PORTS  = 4;
  localparam int TS_W   = 5;
  localparam int DATA_W = 16;
  localparam int REL    = PORTS * LANES;
  localparam int DEPTH  = PORTS * LANES;
  localparam int MASK   = (1 << TS_W) - 1;

  logic                         clk = 1'b0;
  logic                         rst_n;
  logic [LANES-1:0]             lane_vld;
  logic [LANES-1:0][TS_W-1:0]   lane_ts;
  logic [LANES-1:0][DATA_W-1:0] lane_data;
  logic                         out_vld;
  logic [TS_W-1:0]              out_ts;
  logic [DATA_W-1:0]            out_data;
  logic                         err_late;
  logic                         err_ovf;
  logic [TS_W-1:0]              slot_now;

  int errs   = 0;
  int checks = 0;
  int outs   = 0;
  int dcnt   = 1;

  // Behavioural model state
  int m_ts[$];
  int m_dat[$];
  int mnow = 0;
  bit e_vld, e_late, e_ovf;
  int e_ts, e_dat;

  always #4 clk = ~clk;

  reseq_mux #(
    .LANES (LANES), .PORTS (PORTS), .TS_W (TS_W), .DATA_W (DATA_W)
  ) uut (
    .clk (clk), .rst_n (rst_n), .lane_vld (lane_vld), .lane_ts (lane_ts),
    .lane_data (lane_data), .out_vld (out_vld), .out_ts (out_ts),
    .out_data (out_data), .err_late (err_late), .err_ovf (err_ovf),
    .slot_now (slot_now)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(int l, int ts, int d);
    lane_vld[l]  = 1'b1;
    lane_ts[l]   = TS_W'(ts);
    lane_data[l] = DATA_W'(d);
  endtask

  // One line slot: advance the model, clock the design, compare.
  task automatic tick();
    int best, bage, age;
    best = -1;
    bage = -1;
    foreach (m_ts[i]) begin
      age = (mnow - m_ts[i]) & MASK;
      if (age >= REL && age > bage) begin
        bage = age;
        best = i;
      end
    end
    e_vld = (best >= 0);
    if (e_vld) begin
      e_ts  = m_ts[best];
      e_dat = m_dat[best];
      m_ts.delete(best);
      m_dat.delete(best);
    end
    e_late = 1'b0;
    e_ovf  = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_vld[l]) begin
        age = (mnow - int'(lane_ts[l])) & MASK;
        if (age >= REL) e_late = 1'b1;
        else if (m_ts.size() < DEPTH) begin
          m_ts.push_back(int'(lane_ts[l]));
          m_dat.push_back(int'(lane_data[l]));
        end else e_ovf = 1'b1;
      end
    end
    mnow = (mnow + 1) & MASK;
    @(posedge clk);
    @(negedge clk);
    chk(int'(slot_now) == mnow, "R2", "slot_now", int'(slot_now), mnow);
    chk(out_vld == e_vld, e_vld ? "R4" : "R6", "out_vld", int'(out_vld), int'(e_vld));
    if (out_vld && e_vld) begin
      chk(int'(out_ts) == e_ts, "R5", "out_ts", int'(out_ts), e_ts);
      chk(int'(out_data) == e_dat, "R4", "out_data", int'(out_data), e_dat);
    end
    chk(err_late == e_late, "R3", "err_late", int'(err_late), int'(e_late));
    chk(err_ovf == e_ovf, "R8", "err_ovf", int'(err_ovf), int'(e_ovf));
    if (out_vld) outs++;
    lane_vld = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Every third slot all lanes carry cells aged o0, o1, o2.
  task automatic groups(int o0, int o1, int o2, int n);
    for (int g = 0; g < n; g++) begin
      put(0, mnow - o0, dcnt);
      put(1, mnow - o1, dcnt + 1);
      put(2, mnow - o2, dcnt + 2);
      dcnt += 3;
      tick();
      tick();
      tick();
    end
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    checks++;
    $display("FAIL R4 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    lane_vld  = '0;
    lane_ts   = '0;
    lane_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(out_vld == 1'b0, "R1", "out_vld", int'(out_vld), 0);
    chk(err_late == 1'b0, "R1", "err_late", int'(err_late), 0);
    chk(err_ovf == 1'b0, "R1", "err_ovf", int'(err_ovf), 0);
    chk(slot_now == '0, "R1", "slot_now", int'(slot_now), 0);
    rst_n = 1'b1;
    mnow  = 0;

    // R4 lanes already in timestamp order
    outs = 0;
    groups(3, 2, 1, 8);
    idle(16);
    chk(outs == 24, "R4", "ordered stream count", outs, 24);

    // R9 newer cells on lower lanes
    outs = 0;
    groups(1, 2, 3, 8);
    idle(16);
    chk(outs == 24, "R9", "reversed stream count", outs, 24);

    // R9 widely scattered ages
    outs = 0;
    groups(11, 7, 9, 8);
    idle(16);
    chk(outs == 24, "R9", "scattered stream count", outs, 24);

    // R3 boundary ages: REL late, REL-1 kept, future late
    outs = 0;
    put(0, mnow - REL, 900);
    put(1, mnow - (REL - 1), 901);
    put(2, mnow + 1, 902);
    tick();
    chk(err_late == 1'b1, "R3", "late pulse", int'(err_late), 1);
    idle(16);
    chk(outs == 1, "R3", "only in-window cell leaves", outs, 1);

    // R7 full-rate age-0 stream, R8 duplicate on lane 1 overflows
    outs = 0;
    for (int i = 0; i < 20; i++) begin
      put(0, mnow, dcnt);
      if (i == 16) put(1, mnow, dcnt);
      dcnt++;
      tick();
      if (i == 16) chk(err_ovf == 1'b1, "R8", "overflow pulse", int'(err_ovf), 1);
      if (i == 15) chk(err_ovf == 1'b0, "R7", "full buffer no loss", int'(err_ovf), 0);
    end
    idle(16);
    chk(outs == 20, "R7", "full-rate stream count", outs, 20);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule